// File: doc/BRIEF.md
# Edge-Interval Preamble Validator

This block sits behind a demodulator and decides whether the incoming bit stream is a real transmitter preamble or noise. After a start strobe it waits through a fixed start-up period. It then times the gap between successive edges of the synchronized input and compares each gap with a programmable lower and upper bound. Once enough gaps fall inside that window, the block enters a receiving state and forwards the data. A single gap that is too short, or one that grows past the upper bound, sends it to sleep.

The depth of the check is set by a 2-bit bit-count select. Each bit counts as two edge-to-edge gaps. A select of zero skips the check entirely. One-cycle pulses mark the moment of success or failure, so a power controller can react without decoding the state.

Top module: `preamble_validator`

## Requirements
- R1: After reset the state output is sleep (code 0), the data output is low and both pulse outputs are low. The state codes are sleep=0, start-up=1, check=2, receiving=3.
- R2: A start strobe seen at a clock edge puts the block into start-up for exactly STARTUP_CYCLES clocks. Input edges during start-up are ignored.
- R3: With a bit-count select of 0, the block goes directly from start-up to receiving and raises the pass pulse.
- R4: The first edge after start-up only starts the interval timer and is never compared with the window. Time spent in check before that edge cannot cause a failure.
- R5: An edge-to-edge interval of D clocks is accepted when lim_lo <= D <= lim_hi, with both bounds inclusive. After 6 x bit_sel accepted intervals (0, 6, 12 or 18), the block enters receiving.
- R6: An interval shorter than lim_lo moves the block to sleep and raises the fail pulse.
- R7: Once the timer is running, if no edge arrives within lim_hi clocks, the block fails on the next clock without waiting for an edge. A timer-start edge whose input change was applied before clock edge p gives sleep after edge p+lim_hi+3.
- R8: The input passes through a two-flop synchronizer. In receiving, data_out equals the input two clocks later. In every other state data_out is 0.
- R9: Sleep is left only on a start strobe. Receiving persists through any input activity until the next start strobe.
- R10: pass_pulse and fail_pulse each last one clock, never occur together, and appear in the same cycle that the state becomes receiving or sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new start-up and check sequence |
| demod_in | input | 1 | Asynchronous demodulated data |
| lim_lo | input | CNT_W | Shortest accepted interval, in clocks |
| lim_hi | input | CNT_W | Longest accepted interval, in clocks |
| bit_sel | input | 2 | Number of bits to validate: 0, 3, 6 or 9 |
| state | output | 2 | 0 sleep, 1 start-up, 2 check, 3 receiving |
| data_out | output | 1 | Synchronized data, gated to receiving |
| pass_pulse | output | 1 | One-clock pulse on entering receiving |
| fail_pulse | output | 1 | One-clock pulse on a window violation |

## Verification
A wrong accepted-interval count shows at the ports as entry into receiving one or more gaps early or late. That is visible within one interval of the expected edge. A timer that is off by one shows up at the exact window bounds and at the timeout clock, so both bounds and the cycle where the timeout fires are probed directly. A stuck controller state shows as a missing pulse, or as data leaking to data_out outside receiving, within a few clocks of the stimulus.

// File: rtl/pv_pkg.sv
package pv_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP   = 2'd0,
        ST_STARTUP = 2'd1,
        ST_CHECK   = 2'd2,
        ST_RECV    = 2'd3
    } pv_state_e;

    localparam int unsigned EDGES_PER_BIT = 2;
    localparam int unsigned BITS_PER_STEP = 3;
    localparam int unsigned MAX_INTERVALS = EDGES_PER_BIT * BITS_PER_STEP * 3;
endpackage

// File: rtl/pv_edge_sync.sv
module pv_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic sample,
    output logic edge_det
);
    logic [STAGES-1:0] sync_q, sync_d;
    logic              prev_q, prev_d;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign sample   = sync_q[STAGES-1];
    assign edge_det = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pv_interval_timer.sv
module pv_interval_timer #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load_one,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear)
            cnt_d = '0;
        else if (load_one)
            cnt_d = CNT_W'(1);
        else if (cnt_q == CNT_MAX)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R7: the timer saturates instead of wrapping
    a_r7_timer_saturates: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !clear && !load_one) |=> cnt_q == CNT_MAX);
    // R7: a restart always reads back as one
    a_r7_timer_restart: assert property (@(posedge clk) disable iff (rst)
        (load_one && !clear) |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/pv_ctrl.sv
module pv_ctrl
    import pv_pkg::*;
#(
    parameter int unsigned CNT_W          = 12,
    parameter int unsigned STARTUP_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             edge_det,
    input  logic [CNT_W-1:0] interval,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    input  logic [1:0]       bit_sel,
    output pv_state_e        state,
    output logic             timer_clear,
    output logic             timer_load,
    output logic             pass_pulse,
    output logic             fail_pulse
);
    localparam int unsigned SU_W   = $clog2(STARTUP_CYCLES + 1);
    localparam int unsigned PASS_W = $clog2(MAX_INTERVALS + 1);
    localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP_CYCLES - 1);

    typedef struct packed {
        pv_state_e         state;
        logic [SU_W-1:0]   su_cnt;
        logic              armed;
        logic [PASS_W-1:0] npass;
        logic              pass;
        logic              fail;
    } ctrl_t;

    ctrl_t             q, d;
    logic [PASS_W-1:0] need;
    logic [PASS_W-1:0] npass_inc;

    always_comb begin
        need      = PASS_W'(EDGES_PER_BIT * BITS_PER_STEP * bit_sel);
        npass_inc = q.npass + PASS_W'(1);
        d           = q;
        d.pass      = 1'b0;
        d.fail      = 1'b0;
        timer_clear = 1'b0;
        timer_load  = 1'b0;
        if (start) begin
            d.state     = ST_STARTUP;
            d.su_cnt    = '0;
            d.armed     = 1'b0;
            d.npass     = '0;
            timer_clear = 1'b1;
        end else begin
            unique case (q.state)
                ST_SLEEP: timer_clear = 1'b1;
                ST_STARTUP: begin
                    timer_clear = 1'b1;
                    if (q.su_cnt == SU_LAST) begin
                        if (need == '0) begin
                            d.state = ST_RECV;
                            d.pass  = 1'b1;
                        end else begin
                            d.state = ST_CHECK;
                        end
                    end else begin
                        d.su_cnt = q.su_cnt + SU_W'(1);
                    end
                end
                ST_CHECK: begin
                    if (!q.armed) begin
                        if (edge_det) begin
                            d.armed    = 1'b1;
                            timer_load = 1'b1;
                        end else begin
                            timer_clear = 1'b1;
                        end
                    end else if (interval > lim_hi) begin
                        d.state     = ST_SLEEP;
                        d.fail      = 1'b1;
                        timer_clear = 1'b1;
                    end else if (edge_det) begin
                        if (interval < lim_lo) begin
                            d.state     = ST_SLEEP;
                            d.fail      = 1'b1;
                            timer_clear = 1'b1;
                        end else begin
                            d.npass    = npass_inc;
                            timer_load = 1'b1;
                            if (npass_inc == need) begin
                                d.state = ST_RECV;
                                d.pass  = 1'b1;
                            end
                        end
                    end
                end
                ST_RECV: timer_clear = 1'b1;
                default: d.state = ST_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state  <= ST_SLEEP;
            q.su_cnt <= '0;
            q.armed  <= 1'b0;
            q.npass  <= '0;
            q.pass   <= 1'b0;
            q.fail   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state      = q.state;
    assign pass_pulse = q.pass;
    assign fail_pulse = q.fail;

    // R10: success and failure never coincide
    a_r10_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(q.pass && q.fail));
    // R6: a failure pulse comes with sleep
    a_r6_fail_in_sleep: assert property (@(posedge clk) disable iff (rst)
        q.fail |-> q.state == ST_SLEEP);
    // R10: a success pulse comes with receiving
    a_r10_pass_in_recv: assert property (@(posedge clk) disable iff (rst)
        q.pass |-> q.state == ST_RECV);
    // R9: sleep is left only on a start strobe
    a_r9_sleep_holds: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_SLEEP && !start) |=> q.state == ST_SLEEP);
    // R9: receiving is kept until a start strobe
    a_r9_recv_holds: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_RECV && !start) |=> q.state == ST_RECV);
    // R5: while checking, the accepted count stays below the target
    a_r5_count_below_need: assert property (@(posedge clk) disable iff (rst)
        q.state == ST_CHECK |-> q.npass < need);
    // R2: the start-up counter stays within its period
    a_r2_startup_bounded: assert property (@(posedge clk) disable iff (rst)
        q.state == ST_STARTUP |-> q.su_cnt <= SU_LAST);
    // R4: before the first edge the timer is held at zero
    a_r4_unarmed_idle_timer: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_CHECK && !q.armed) |-> interval == '0);
endmodule

// File: rtl/preamble_validator.sv
module preamble_validator
    import pv_pkg::*;
#(
    parameter int unsigned CNT_W          = 12,
    parameter int unsigned STARTUP_CYCLES = 16,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             demod_in,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    input  logic [1:0]       bit_sel,
    output logic [1:0]       state,
    output logic             data_out,
    output logic             pass_pulse,
    output logic             fail_pulse
);
    logic             sample;
    logic             edge_det;
    logic             timer_clear;
    logic             timer_load;
    logic [CNT_W-1:0] interval;
    pv_state_e        st;

    pv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .din      (demod_in),
        .sample   (sample),
        .edge_det (edge_det)
    );

    pv_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear    (timer_clear),
        .load_one (timer_load),
        .count    (interval)
    );

    pv_ctrl #(.CNT_W(CNT_W), .STARTUP_CYCLES(STARTUP_CYCLES)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .edge_det    (edge_det),
        .interval    (interval),
        .lim_lo      (lim_lo),
        .lim_hi      (lim_hi),
        .bit_sel     (bit_sel),
        .state       (st),
        .timer_clear (timer_clear),
        .timer_load  (timer_load),
        .pass_pulse  (pass_pulse),
        .fail_pulse  (fail_pulse)
    );

    assign state    = st;
    assign data_out = (st == ST_RECV) && sample;

    // R8: data leaves the block only while receiving
    a_r8_data_gated: assert property (@(posedge clk) disable iff (rst)
        data_out |-> state == 2'd3);
endmodule

// File: tb/tb_preamble_validator.sv
module tb_preamble_validator;
    localparam int CNT_W = 12;
    localparam int SU    = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             demod_in = 1'b0;
    logic [CNT_W-1:0] lim_lo = '0;
    logic [CNT_W-1:0] lim_hi = '0;
    logic [1:0]       bit_sel = '0;
    logic [1:0]       state;
    logic             data_out;
    logic             pass_pulse;
    logic             fail_pulse;

    int checks = 0;
    int errors = 0;
    int pass_seen = 0;
    int fail_seen = 0;
    int iv [0:31];
    int niv;

    preamble_validator #(.CNT_W(CNT_W), .STARTUP_CYCLES(SU)) dut (
        .clk(clk), .rst(rst), .start(start), .demod_in(demod_in),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .bit_sel(bit_sel),
        .state(state), .data_out(data_out),
        .pass_pulse(pass_pulse), .fail_pulse(fail_pulse)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (pass_pulse) pass_seen++;
        if (fail_pulse) fail_seen++;
    end

    initial begin
        #3_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        pass_seen = 0;
        fail_seen = 0;
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic toggle();
        demod_in = ~demod_in;
    endtask

    // reference: expected final state for an interval list
    function automatic int predict(input int lo, input int hi, input int sel, input int n);
        int need = 6 * sel;
        int ok = 0;
        if (need == 0) return 3;
        for (int i = 0; i < n; i++) begin
            if (iv[i] < lo || iv[i] > hi) return 0;
            ok++;
            if (ok == need) return 3;
        end
        return 2;
    endfunction

    task automatic run_seq(input int lo, input int hi, input int sel, input string req);
        int exp;
        lim_lo = CNT_W'(lo);
        lim_hi = CNT_W'(hi);
        bit_sel = 2'(sel);
        do_start();
        tick(SU + 2);
        if (sel != 0) begin
            toggle();
            for (int i = 0; i < niv; i++) begin
                tick(iv[i]);
                toggle();
            end
        end
        tick(4);
        exp = predict(lo, hi, sel, niv);
        chk(int'(state) == exp, req, int'(state), exp);
        if (exp == 3) chk(pass_seen == 1 && fail_seen == 0, "R10 pass pulse", pass_seen, 1);
        if (exp == 0) chk(fail_seen == 1 && pass_seen == 0, "R10 fail pulse", fail_seen, 1);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk(state == 2'd0, "R1 state", int'(state), 0);
        chk(data_out == 1'b0 && pass_pulse == 1'b0 && fail_pulse == 1'b0, "R1 outputs",
            int'(data_out) + int'(pass_pulse) + int'(fail_pulse), 0);

        // R9 sleep ignores input activity
        for (int i = 0; i < 6; i++) begin toggle(); tick(3); end
        chk(state == 2'd0, "R9 sleep holds", int'(state), 0);
        demod_in = 1'b1;
        tick(3);
        chk(data_out == 1'b0, "R8 data low in sleep", int'(data_out), 0);
        demod_in = 1'b0;
        tick(3);

        // R2 start-up length and ignored edges
        lim_lo = 4; lim_hi = 6; bit_sel = 1;
        do_start();
        for (int i = 0; i < SU - 4; i++) begin toggle(); tick(1); end
        if (demod_in) begin toggle(); end
        tick(3);
        chk(state == 2'd1, "R2 still start-up", int'(state), 1);
        tick(1);
        chk(state == 2'd2, "R2 check after start-up", int'(state), 2);
        chk(fail_seen == 0 && pass_seen == 0, "R2 edges ignored", fail_seen + pass_seen, 0);

        // R4 long wait before first edge does not fail
        tick(40);
        chk(state == 2'd2, "R4 no timeout before first edge", int'(state), 2);

        // R7 exact timeout: toggle arms timer
        toggle();
        tick(6 + 3);
        chk(state == 2'd2, "R7 before timeout", int'(state), 2);
        tick(1);
        chk(state == 2'd0, "R7 timeout to sleep", int'(state), 0);
        chk(fail_pulse == 1'b1, "R7 fail pulse on timeout", int'(fail_pulse), 1);
        tick(1);
        chk(fail_pulse == 1'b0, "R10 pulse one clock", int'(fail_pulse), 0);

        // R3 zero bits straight to receiving
        niv = 0;
        run_seq(4, 6, 0, "R3 zero-bit select");

        // R5 boundaries inclusive
        niv = 6;
        for (int i = 0; i < 6; i++) iv[i] = (i % 2) ? 5 : 9;
        run_seq(5, 9, 1, "R5 bounds inclusive");
        // R8 forwarding in receiving
        demod_in = ~demod_in;
        tick(2);
        chk(data_out == demod_in, "R8 data follows input", int'(data_out), int'(demod_in));
        demod_in = ~demod_in;
        tick(2);
        chk(data_out == demod_in, "R8 data follows input 2", int'(data_out), int'(demod_in));
        // R9 receiving holds through odd activity
        for (int i = 0; i < 5; i++) begin toggle(); tick(1); end
        chk(state == 2'd3, "R9 receiving holds", int'(state), 3);

        // R6 one below lower bound
        niv = 3;
        iv[0] = 5; iv[1] = 5; iv[2] = 4;
        run_seq(5, 9, 2, "R6 short interval");
        // R7 one above upper bound
        niv = 2;
        iv[0] = 9; iv[1] = 10;
        run_seq(5, 9, 2, "R7 long interval");
        // R5 full 18 intervals
        niv = 18;
        for (int i = 0; i < 18; i++) iv[i] = 7;
        run_seq(6, 8, 3, "R5 nine bits");

        // random trials
        for (int t = 0; t < 40; t++) begin
            int lo, hi, sel, need;
            lo = 3 + int'($urandom_range(0, 12));
            hi = lo + int'($urandom_range(0, 8));
            sel = int'($urandom_range(0, 3));
            need = 6 * sel;
            niv = 0;
            for (int i = 0; i < need; i++) begin
                int d;
                if ($urandom_range(0, 19) == 0)
                    d = ($urandom_range(0, 1) == 1) ? hi + 1 + int'($urandom_range(0, 2))
                                                     : lo - 1 - int'($urandom_range(0, 1));
                else
                    d = lo + int'($urandom_range(0, hi - lo));
                if (d < 1) d = 1;
                iv[i] = d;
                niv++;
                if (d < lo || d > hi) break;
            end
            run_seq(lo, hi, sel, "R5 random trial");
            if (state == 2'd0) begin
                demod_in = 1'b1;
                tick(3);
                chk(data_out == 1'b0, "R8 random data low", int'(data_out), 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule